// File: doc/BRIEF.md
# Multiplexed-Bus Machine Cycle Sequencer

This block sits between a small 8-bit processor core and its external pins. It turns each bus request from the core into a timed machine cycle. A request names one of five cycle kinds, a 16-bit address and a write byte. The cycle kinds are opcode fetch, memory read, memory write, port read and port write.

The sequencer steps through numbered T-states. It puts the low address byte on a shared address/data bus while the address latch strobe is high, and drives the upper byte on dedicated lines. It then moves the data with active-low read or write strobes. A status pair and a memory/port select tell external logic which kind of cycle is running.

A slow device can stretch a cycle by holding the ready input low. An external master can take over the bus with a hold request. That request is granted only between machine cycles, and once it is granted every output enable drops.

The core starts a cycle by raising `req_valid` and keeping the request stable until `req_accept` is high. It learns that the cycle is over, and picks up any read byte, from a one-cycle `req_done` pulse.

Top module: `bus_cycle_seq`

## Requirements
- R1: During and right after reset, `rd_n` and `wr_n` are 1, `ale` is 0, `hlda` is 0, `req_done` is 0 and `req_accept` is 0.
- R2: Opcode fetch (`req_kind` 0) takes four T-states:
  - `ale`=1 in T1, with the address low byte on `ad_out` and `ad_oe`=1.
  - `rd_n`=0 in T2 and T3.
  - In T4, `rd_n`=1 and `ad_oe`=0.
  - {`s1`,`s0`}=11 and `io_m`=0 from T1 to T4.
- R3: Memory read (`req_kind` 1) takes three T-states. {`s1`,`s0`}=10 and `io_m`=0. `rd_n`=0 in T2 and T3, `wr_n` stays 1 and `ad_oe`=0 after T1.
- R4: Memory write (`req_kind` 2) takes three T-states. {`s1`,`s0`}=01 and `io_m`=0. In T2 and T3, `wr_n`=0 and `ad_out` carries the write byte with `ad_oe`=1. `rd_n` stays 1. `rd_n` and `wr_n` are never low together.
- R5: Port read (`req_kind` 3) and port write (`req_kind` 4) take three T-states with `io_m`=1. Their {`s1`,`s0`} values are 10 and 01 respectively. The 8-bit port number (address low byte) appears on `addr_hi` throughout, and on `ad_out` in T1.
- R6: `addr_hi`, `s1`, `s0` and `io_m` do not change from T1 to the last T-state of a cycle.
- R7: `ready` is sampled at the end of T2 and of every wait state. While it is 0, wait states are inserted between T2 and T3 with the strobe held low and `ale`=0.
- R8: `req_done` is high for exactly the one clock after the last T-state. For fetch and read kinds, `rd_data` then equals the value `ad_in` had at the end of T3.
- R9: A `hold` raised during a cycle lets that cycle finish, and `hlda` rises in the next clock. `hold` takes priority over a pending request in idle. No request is accepted while `hlda` is 1.
- R10: While `hlda` is 1, `ad_oe`, `addr_hi_oe` and `ctrl_oe` are 0.
- R11: `req_kind` values 5 to 7 are never accepted: `req_accept` stays 0 and no `ale` pulse follows.
- R12: `req_accept` is high only in idle, and only when there is a valid legal request and no hold. `ale` is high in the clock after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | T-state clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Core requests a machine cycle |
| req_kind | input | 3 | Cycle kind code (0 fetch, 1 mem read, 2 mem write, 3 port read, 4 port write) |
| req_addr | input | ADDR_W | Cycle address; the low byte is the port number for port kinds |
| req_wdata | input | DATA_W | Byte to write |
| req_accept | output | 1 | Request taken this clock |
| req_done | output | 1 | One-clock pulse after the cycle's last T-state |
| rd_data | output | DATA_W | Byte captured at the end of T3 |
| ready | input | 1 | Slow-device ready, low inserts waits |
| hold | input | 1 | External bus request |
| hlda | output | 1 | Bus handed over |
| ad_in | input | DATA_W | Shared bus, incoming value |
| ad_out | output | DATA_W | Shared bus, driven value |
| ad_oe | output | 1 | Shared bus drive enable |
| addr_hi | output | ADDR_W-DATA_W | Upper address lines |
| addr_hi_oe | output | 1 | Upper address drive enable |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| io_m | output | 1 | 1 for port cycles, 0 for memory |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| ctrl_oe | output | 1 | Enable for ale, strobes and status |

## Verification
The hardest situation to reach is a hold request that arrives in the middle of a stretched cycle. The grant must wait for the cycle to finish, the completion pulse must still appear, and a request kept pending must then be refused for as long as the bus is handed over.

The stimulus gets there as follows:
- It starts a memory read and keeps `ready` low for several wait states.
- It raises `hold` during those waits.
- It keeps `req_valid` high with a fresh request across the boundary.
- It checks each T-state at the pins, then the grant and the refused request, and finally a normal cycle after `hold` drops.

A second case raises `hold` and a request together in idle, to show the priority.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

   typedef enum logic [2:0] {
      CYC_FETCH = 3'd0,
      CYC_MEMRD = 3'd1,
      CYC_MEMWR = 3'd2,
      CYC_IORD  = 3'd3,
      CYC_IOWR  = 3'd4
   } cyc_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_T1   = 3'd1,
      ST_T2   = 3'd2,
      ST_TW   = 3'd3,
      ST_T3   = 3'd4,
      ST_T4   = 3'd5,
      ST_HOLD = 3'd6
   } tstate_e;

   typedef struct packed {
      logic legal;
      logic stat1;
      logic stat0;
      logic port_sel;
      logic is_write;
      logic is_fetch;
   } cyc_attr_t;

endpackage

// File: rtl/bcs_status_enc.sv
module bcs_status_enc
   import bcs_pkg::*;
(
   input  logic [2:0] kind,
   output cyc_attr_t  attr
);

   always_comb begin
      attr = '0;
      unique case (kind)
         CYC_FETCH: attr = '{legal:1'b1, stat1:1'b1, stat0:1'b1, port_sel:1'b0, is_write:1'b0, is_fetch:1'b1};
         CYC_MEMRD: attr = '{legal:1'b1, stat1:1'b1, stat0:1'b0, port_sel:1'b0, is_write:1'b0, is_fetch:1'b0};
         CYC_MEMWR: attr = '{legal:1'b1, stat1:1'b0, stat0:1'b1, port_sel:1'b0, is_write:1'b1, is_fetch:1'b0};
         CYC_IORD:  attr = '{legal:1'b1, stat1:1'b1, stat0:1'b0, port_sel:1'b1, is_write:1'b0, is_fetch:1'b0};
         CYC_IOWR:  attr = '{legal:1'b1, stat1:1'b0, stat0:1'b1, port_sel:1'b1, is_write:1'b1, is_fetch:1'b0};
         default:   attr = '0;
      endcase
   end

endmodule

// File: rtl/bcs_tstate_fsm.sv
module bcs_tstate_fsm
   import bcs_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    start,
   input  logic    is_fetch,
   input  logic    ready,
   input  logic    hold,
   output tstate_e state,
   output logic    last_t
);

   tstate_e nxt;

   assign last_t = (state == ST_T4) || (state == ST_T3 && !is_fetch);

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE: if (hold) nxt = ST_HOLD; else if (start) nxt = ST_T1;
         ST_T1:   nxt = ST_T2;
         ST_T2:   nxt = ready ? ST_T3 : ST_TW;
         ST_TW:   nxt = ready ? ST_T3 : ST_TW;
         ST_T3:   if (is_fetch) nxt = ST_T4; else nxt = hold ? ST_HOLD : ST_IDLE;
         ST_T4:   nxt = hold ? ST_HOLD : ST_IDLE;
         ST_HOLD: nxt = hold ? ST_HOLD : ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   // R7: a low ready keeps the sequencer in the wait state
   p_wait_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TW && !ready) |=> (state == ST_TW));

   // R9: a new cycle never begins straight out of a hold
   p_hold_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD) |=> (state == ST_HOLD || state == ST_IDLE));

endmodule

// File: rtl/bcs_pin_drv.sv
module bcs_pin_drv
   import bcs_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter bit PORT_MIRROR = 1'b1,
   localparam int HI_W       = ADDR_W - DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  tstate_e           state,
   input  cyc_attr_t         attr,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic [DATA_W-1:0] wdata_q,
   output logic [HI_W-1:0]   addr_hi,
   output logic              addr_hi_oe,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   output logic              ale,
   output logic              rd_n,
   output logic              wr_n,
   output logic              io_m,
   output logic              s1,
   output logic              s0,
   output logic              ctrl_oe
);

   logic [HI_W-1:0] port_hi;
   logic            in_cycle;
   logic            xfer;

   generate
      if (PORT_MIRROR) begin : g_mirror
         assign port_hi = HI_W'(addr_q[DATA_W-1:0]);
      end else begin : g_zero
         assign port_hi = '0;
      end
   endgenerate

   assign in_cycle = (state == ST_T1) || (state == ST_T2) || (state == ST_TW) ||
                     (state == ST_T3) || (state == ST_T4);
   assign xfer     = (state == ST_T2) || (state == ST_TW) || (state == ST_T3);

   always_comb begin
      addr_hi    = attr.port_sel ? port_hi : addr_q[ADDR_W-1:DATA_W];
      addr_hi_oe = (state != ST_HOLD);
      ctrl_oe    = (state != ST_HOLD);
      ale        = (state == ST_T1);
      rd_n       = !(xfer && attr.legal && !attr.is_write);
      wr_n       = !(xfer && attr.legal && attr.is_write);
      io_m       = in_cycle && attr.port_sel;
      s1         = in_cycle && attr.stat1;
      s0         = in_cycle && attr.stat0;
      ad_oe      = (state == ST_T1) || (xfer && attr.is_write);
      if (state == ST_T1)               ad_out = addr_q[DATA_W-1:0];
      else if (xfer && attr.is_write)   ad_out = wdata_q;
      else                              ad_out = '0;
   end

   // R4: the two strobes are never active together
   p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));

   // R2: the address strobe lasts one clock
   p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> !ale);

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
   import bcs_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter bit PORT_MIRROR = 1'b1,
   localparam int HI_W       = ADDR_W - DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_accept,
   output logic              req_done,
   output logic [DATA_W-1:0] rd_data,
   input  logic              ready,
   input  logic              hold,
   output logic              hlda,
   input  logic [DATA_W-1:0] ad_in,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   output logic [HI_W-1:0]   addr_hi,
   output logic              addr_hi_oe,
   output logic              ale,
   output logic              rd_n,
   output logic              wr_n,
   output logic              io_m,
   output logic              s1,
   output logic              s0,
   output logic              ctrl_oe
);

   generate
      if (ADDR_W <= DATA_W) begin : g_bad_widths
         $error("bus_cycle_seq: ADDR_W must exceed DATA_W");
      end
      if (PORT_MIRROR && (HI_W != DATA_W)) begin : g_bad_mirror
         $error("bus_cycle_seq: port mirroring needs equal address halves");
      end
   endgenerate

   cyc_attr_t         attr_in, attr_q;
   tstate_e           state;
   logic              last_t;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;

   bcs_status_enc u_enc (
      .kind (req_kind),
      .attr (attr_in)
   );

   assign req_accept = (state == ST_IDLE) && req_valid && attr_in.legal && !hold;
   assign hlda       = (state == ST_HOLD);

   bcs_tstate_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (req_accept),
      .is_fetch (attr_q.is_fetch),
      .ready    (ready),
      .hold     (hold),
      .state    (state),
      .last_t   (last_t)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         attr_q   <= '0;
         addr_q   <= '0;
         wdata_q  <= '0;
         rd_data  <= '0;
         req_done <= 1'b0;
      end else begin
         req_done <= last_t;
         if (req_accept) begin
            attr_q  <= attr_in;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
         if (state == ST_T3 && !attr_q.is_write) rd_data <= ad_in;
      end
   end

   bcs_pin_drv #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .PORT_MIRROR (PORT_MIRROR)
   ) u_drv (
      .clk        (clk),
      .rst_n      (rst_n),
      .state      (state),
      .attr       (attr_q),
      .addr_q     (addr_q),
      .wdata_q    (wdata_q),
      .addr_hi    (addr_hi),
      .addr_hi_oe (addr_hi_oe),
      .ad_out     (ad_out),
      .ad_oe      (ad_oe),
      .ale        (ale),
      .rd_n       (rd_n),
      .wr_n       (wr_n),
      .io_m       (io_m),
      .s1         (s1),
      .s0         (s0),
      .ctrl_oe    (ctrl_oe)
   );

   // R10: the bus is fully released while handed over
   p_hold_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      hlda |-> (!ad_oe && !addr_hi_oe && !ctrl_oe));

   // R9: no request is taken while the bus is handed over
   p_hold_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hlda |-> !req_accept);

   // R12: an accepted request opens with the address strobe
   p_accept_ale_r12: assert property (@(posedge clk) disable iff (!rst_n)
      req_accept |=> ale);

   // R11: codes above the port-write kind are refused
   p_illegal_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind > 3'd4) |-> !req_accept);

   // R6: upper address and status hold steady after T1
   p_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_T2 || state == ST_TW || state == ST_T3 || state == ST_T4)
      |-> $stable({addr_hi, s1, s0, io_m}));

endmodule

// File: tb/bus_cycle_seq_tb_top.sv
module bus_cycle_seq_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [2:0] req_kind = 3'd0;
   logic [15:0] req_addr = '0;
   logic [7:0] req_wdata = '0;
   logic       req_accept, req_done;
   logic [7:0] rd_data;
   logic       ready = 1'b1;
   logic       hold = 1'b0;
   logic       hlda;
   logic [7:0] ad_in = '0;
   logic [7:0] ad_out;
   logic       ad_oe;
   logic [7:0] addr_hi;
   logic       addr_hi_oe, ale, rd_n, wr_n, io_m, s1, s0, ctrl_oe;

   int n_chk = 0;
   int n_bad = 0;
   bit all_done = 1'b0;

   always #4 clk = ~clk;

   bus_cycle_seq dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_accept(req_accept),
      .req_done(req_done), .rd_data(rd_data), .ready(ready), .hold(hold),
      .hlda(hlda), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
      .addr_hi(addr_hi), .addr_hi_oe(addr_hi_oe), .ale(ale), .rd_n(rd_n),
      .wr_n(wr_n), .io_m(io_m), .s1(s1), .s0(s0), .ctrl_oe(ctrl_oe)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1", "rd_n in reset", rd_n, 1);
      chk("R1", "wr_n in reset", wr_n, 1);
      chk("R1", "ale in reset", ale, 0);
      chk("R1", "hlda in reset", hlda, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "req_done after reset", req_done, 0);
      chk("R1", "req_accept after reset", req_accept, 0);
      chk("R1", "strobes after reset", {rd_n, wr_n, ale}, 3'b110);
   endtask

   // one complete machine cycle, checked in every T-state
   task automatic t_cycle(input string req, input logic [2:0] kind,
                          input logic [15:0] addr, input logic [7:0] wd,
                          input int waits, input logic [7:0] rv);
      logic [7:0] ehi;
      logic [1:0] est;
      logic       eio, is_wr;
      eio   = (kind >= 3'd3);
      is_wr = (kind == 3'd2) || (kind == 3'd4);
      ehi   = eio ? addr[7:0] : addr[15:8];
      case (kind)
         3'd0: est = 2'b11;
         3'd1, 3'd3: est = 2'b10;
         default: est = 2'b01;
      endcase
      @(negedge clk);
      req_valid = 1'b1; req_kind = kind; req_addr = addr; req_wdata = wd;
      #1;
      chk("R12", "accept in idle", req_accept, 1);
      @(negedge clk);
      req_valid = 1'b0;
      if (waits > 0) ready = 1'b0;
      chk(req, "T1 ale", ale, 1);
      chk(req, "T1 ad_out", ad_out, addr[7:0]);
      chk(req, "T1 ad_oe", ad_oe, 1);
      chk(req, "T1 status", {s1, s0, io_m}, {est, eio});
      chk("R6", "T1 addr_hi", addr_hi, ehi);
      chk(req, "T1 strobes", {rd_n, wr_n}, 2'b11);
      @(negedge clk);
      chk(req, "T2 rd_n", rd_n, is_wr);
      chk(req, "T2 wr_n", wr_n, !is_wr);
      chk(req, "T2 ale", ale, 0);
      if (is_wr) chk("R4", "T2 write byte", {ad_oe, ad_out}, {1'b1, wd});
      else       chk(req, "T2 ad_oe", ad_oe, 0);
      for (int w = 0; w < waits; w++) begin
         @(negedge clk);
         if (w == waits - 1) ready = 1'b1;
         chk("R7", "wait strobe held", {rd_n, wr_n}, is_wr ? 2'b10 : 2'b01);
         chk("R7", "wait ale low", ale, 0);
         chk("R6", "wait addr_hi", addr_hi, ehi);
      end
      @(negedge clk);
      ad_in = rv;
      chk(req, "T3 strobes", {rd_n, wr_n}, is_wr ? 2'b10 : 2'b01);
      chk("R6", "T3 status", {s1, s0, io_m, addr_hi}, {est, eio, ehi});
      chk("R9", "T3 no hlda", hlda, 0);
      if (kind == 3'd0) begin
         @(negedge clk);
         chk("R2", "T4 rd_n high", rd_n, 1);
         chk("R2", "T4 bus released", ad_oe, 0);
         chk("R2", "T4 status", {s1, s0, io_m}, 3'b110);
         chk("R2", "T4 no done yet", req_done, 0);
      end else begin
         chk(req, "T3 no done yet", req_done, 0);
      end
      @(negedge clk);
      ad_in = 8'h00;
      chk("R8", "done pulse", req_done, 1);
      if (!is_wr) chk("R8", "read byte", rd_data, rv);
      chk(req, "end strobes", {rd_n, wr_n, ale}, 3'b110);
      @(negedge clk);
      chk("R8", "done single clock", req_done, 0);
   endtask

   task automatic t_illegal();
      for (int k = 5; k < 8; k++) begin
         @(negedge clk);
         req_valid = 1'b1; req_kind = 3'(k);
         #1;
         chk("R11", "illegal not accepted", req_accept, 0);
         @(negedge clk);
         chk("R11", "no ale after illegal", ale, 0);
         req_valid = 1'b0;
      end
   endtask

   task automatic t_hold_mid();
      @(negedge clk);
      req_valid = 1'b1; req_kind = 3'd1; req_addr = 16'h5A3C;
      #1;
      chk("R12", "accept before hold", req_accept, 1);
      @(negedge clk);                       // T1
      req_kind = 3'd0; req_addr = 16'h0102; // pending next request
      ready = 1'b0;
      @(negedge clk);                       // T2
      hold = 1'b1;
      chk("R9", "hold waits for cycle", hlda, 0);
      @(negedge clk);                       // TW
      chk("R9", "still in cycle", {hlda, rd_n}, 2'b00);
      @(negedge clk);                       // TW
      ready = 1'b1;
      chk("R9", "still waiting", {hlda, rd_n}, 2'b00);
      @(negedge clk);                       // T3
      ad_in = 8'hC3;
      chk("R9", "T3 under hold", {hlda, rd_n}, 2'b00);
      @(negedge clk);                       // hold granted
      chk("R9", "hlda at boundary", hlda, 1);
      chk("R8", "done under hold", req_done, 1);
      chk("R8", "read byte under hold", rd_data, 8'hC3);
      chk("R10", "enables off", {ad_oe, addr_hi_oe, ctrl_oe}, 3'b000);
      #1;
      chk("R9", "pending refused", req_accept, 0);
      repeat (3) @(negedge clk);
      chk("R9", "hold kept", {hlda, ale}, 2'b10);
      chk("R10", "enables still off", {ad_oe, addr_hi_oe, ctrl_oe}, 3'b000);
      req_valid = 1'b0;
      hold = 1'b0;
      ad_in = 8'h00;
      @(negedge clk);
      chk("R9", "hlda released", hlda, 0);
      chk("R10", "enables back", {addr_hi_oe, ctrl_oe}, 2'b11);
   endtask

   task automatic t_hold_idle();
      @(negedge clk);
      hold = 1'b1; req_valid = 1'b1; req_kind = 3'd2;
      #1;
      chk("R9", "hold beats request", req_accept, 0);
      @(negedge clk);
      chk("R9", "granted from idle", {hlda, ale}, 2'b10);
      req_valid = 1'b0;
      hold = 1'b0;
      @(negedge clk);
      chk("R9", "released from idle", hlda, 0);
   endtask

   initial begin
      #(8 * 20000);
      if (!all_done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_cycle("R2", 3'd0, 16'h1234, 8'h00, 0, 8'hA5);
      t_cycle("R3", 3'd1, 16'hC200, 8'h00, 0, 8'h5E);
      t_cycle("R4", 3'd2, 16'h8001, 8'h96, 0, 8'h00);
      t_cycle("R5", 3'd3, 16'hFF47, 8'h00, 0, 8'h3B);
      t_cycle("R5", 3'd4, 16'h0099, 8'h6D, 0, 8'h00);
      t_cycle("R7", 3'd1, 16'h4321, 8'h00, 3, 8'h77);
      t_cycle("R7", 3'd0, 16'hABCD, 8'h00, 1, 8'h18);
      t_cycle("R7", 3'd2, 16'h2468, 8'hE1, 2, 8'h00);
      t_illegal();
      t_hold_mid();
      t_cycle("R9", 3'd3, 16'h0010, 8'h00, 0, 8'h42);
      t_hold_idle();
      all_done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule